// File: doc/BRIEF.md
# Packed SIMD Widening Adder

This block adds packed integer lanes and writes double-width sums. A 64-bit second operand is always split into narrow lanes of 8, 16 or 32 bits. The first operand comes from one of two inputs, chosen by a shape-select bit. In long shape it is a 64-bit vector of narrow lanes. In wide shape it is a 128-bit vector whose lanes are already double width. Narrow lanes are sign-extended or zero-extended to twice their width before the add, so the 128-bit result holds 8, 4 or 2 double-width lanes.

The datapath is combinational. An output register stage follows it and is present by default. A lane-size code of 2'b11 is not a valid encoding. It raises an invalid-operation flag and forces the result to zero. The block has no handshake: every clock it takes one operation and, with the register present, presents the result one cycle later.

Top module: `simd_widen_add`

## Requirements
- R1: With `shape_wide`=0 (long shape), result lane e equals extended `opa_narrow` lane e plus extended `opb` lane e. The lane size is selected by `lane_sz`: 2'b00 gives 8-bit lanes (8 lanes), 2'b01 gives 16-bit lanes (4 lanes) and 2'b10 gives 32-bit lanes (2 lanes). Result lanes are twice the source width, and lane 0 sits in the least significant bits of every vector.
- R2: With `shape_wide`=1 (wide shape), the first addend of result lane e is `opa_wide` bits [e*2W +: 2W], used without change, where W is the narrow lane width.
- R3: `zero_ext`=0 sign-extends each narrow lane and `zero_ext`=1 zero-extends it. In wide shape this applies only to `opb`.
- R4: Each result lane wraps modulo 2^(2W), and no carry passes from one lane into the next.
- R5: `lane_sz`=2'b11 sets `bad_op`=1 and `sum_out`=0. Every valid size gives `bad_op`=0.
- R6: The unused first-operand input has no effect on the result: `opa_wide` in long shape and `opa_narrow` in wide shape.
- R7: With `REG_OUT`=1 (the default), `sum_out` and `bad_op` reflect the inputs sampled at the previous rising clock edge.
- R8: A synchronous active-high `rst` clears `sum_out` and `bad_op` to zero at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shape_wide | input | 1 | 0 selects long shape, 1 selects wide shape |
| zero_ext | input | 1 | 1 zero-extends narrow lanes, 0 sign-extends them |
| lane_sz | input | 2 | Narrow lane size code |
| opa_wide | input | 128 | First operand with double-width lanes, used in wide shape |
| opa_narrow | input | 64 | First operand with narrow lanes, used in long shape |
| opb | input | 64 | Second operand with narrow lanes |
| sum_out | output | 128 | Double-width lane sums |
| bad_op | output | 1 | Invalid lane-size flag |

## Verification
The bench drives narrow lanes whose sign bit is set in both signed and unsigned mode. A design that extends with the wrong fill gives upper halves that are off by 0xFF..00 in those lanes. It also puts all-ones values next to lane boundaries in wide shape. A design that lets a carry cross a lane boundary changes the lane above, where every lane should wrap to zero. Further vectors use lane-size code 2'b11 with busy operands, change only the unused first-operand input, and assert reset while operands are live. These catch a missing flag, leakage from the unused input, and stale outputs after reset.

// File: rtl/swa_pkg.sv
package swa_pkg;
    localparam int NARROW_W = 64;
    localparam int WIDE_W   = 2 * NARROW_W;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_BAD  = 2'b11
    } lane_sz_e;
endpackage

// File: rtl/swa_lane_group.sv
module swa_lane_group #(
    parameter int ESIZE = 8,
    parameter int NW    = 64
) (
    input  logic            shape_wide,
    input  logic            zero_ext,
    input  logic [2*NW-1:0] opa_wide,
    input  logic [NW-1:0]   opa_narrow,
    input  logic [NW-1:0]   opb,
    output logic [2*NW-1:0] res
);
    localparam int LANES = NW / ESIZE;
    localparam int DW    = 2 * ESIZE;

    for (genvar e = 0; e < LANES; e++) begin : g_lane
        logic [ESIZE-1:0] a_n;
        logic [ESIZE-1:0] b_n;
        logic [DW-1:0]    a_x;
        logic [DW-1:0]    b_x;
        logic [DW-1:0]    a_sel;

        assign a_n   = opa_narrow[e*ESIZE +: ESIZE];
        assign b_n   = opb[e*ESIZE +: ESIZE];
        assign a_x   = {{ESIZE{~zero_ext & a_n[ESIZE-1]}}, a_n};
        assign b_x   = {{ESIZE{~zero_ext & b_n[ESIZE-1]}}, b_n};
        assign a_sel = shape_wide ? opa_wide[e*DW +: DW] : a_x;
        assign res[e*DW +: DW] = a_sel + b_x;
    end
endmodule

// File: rtl/swa_select.sv
module swa_select
    import swa_pkg::*;
#(
    parameter int WW = 128
) (
    input  lane_sz_e        lane_sz,
    input  logic [WW-1:0]   res_byte,
    input  logic [WW-1:0]   res_half,
    input  logic [WW-1:0]   res_word,
    output logic [WW-1:0]   result,
    output logic            bad
);
    always_comb begin
        unique case (lane_sz)
            SZ_BYTE: begin result = res_byte; bad = 1'b0; end
            SZ_HALF: begin result = res_half; bad = 1'b0; end
            SZ_WORD: begin result = res_word; bad = 1'b0; end
            default: begin result = '0;       bad = 1'b1; end
        endcase
    end
endmodule

// File: rtl/swa_out_stage.sv
module swa_out_stage #(
    parameter int WW      = 128,
    parameter bit REG_OUT = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [WW-1:0] d_sum,
    input  logic          d_bad,
    output logic [WW-1:0] q_sum,
    output logic          q_bad
);
    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q_sum <= '0;
                q_bad <= 1'b0;
            end else begin
                q_sum <= d_sum;
                q_bad <= d_bad;
            end
        end
    end else begin : g_comb
        logic unused_ctl;
        assign unused_ctl = clk ^ rst;
        assign q_sum = d_sum;
        assign q_bad = d_bad;
    end
endmodule

// File: rtl/simd_widen_add.sv
module simd_widen_add
    import swa_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shape_wide,
    input  logic                zero_ext,
    input  logic [1:0]          lane_sz,
    input  logic [WIDE_W-1:0]   opa_wide,
    input  logic [NARROW_W-1:0] opa_narrow,
    input  logic [NARROW_W-1:0] opb,
    output logic [WIDE_W-1:0]   sum_out,
    output logic                bad_op
);
    localparam int NUM_SIZES = 3;

    logic [WIDE_W-1:0] res_by_size [NUM_SIZES];
    logic [WIDE_W-1:0] comb_sum;
    logic              comb_bad;

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
        swa_lane_group #(
            .ESIZE (8 << s),
            .NW    (NARROW_W)
        ) lanes_i (
            .shape_wide (shape_wide),
            .zero_ext   (zero_ext),
            .opa_wide   (opa_wide),
            .opa_narrow (opa_narrow),
            .opb        (opb),
            .res        (res_by_size[s])
        );
    end

    swa_select #(.WW(WIDE_W)) sel_i (
        .lane_sz  (lane_sz_e'(lane_sz)),
        .res_byte (res_by_size[0]),
        .res_half (res_by_size[1]),
        .res_word (res_by_size[2]),
        .result   (comb_sum),
        .bad      (comb_bad)
    );

    swa_out_stage #(.WW(WIDE_W), .REG_OUT(REG_OUT)) out_i (
        .clk   (clk),
        .rst   (rst),
        .d_sum (comb_sum),
        .d_bad (comb_bad),
        .q_sum (sum_out),
        .q_bad (bad_op)
    );
endmodule

// File: rtl/swa_checker.sv
module swa_checker #(
    parameter bit REG_OUT = 1'b1
) (
    input logic         clk,
    input logic         rst,
    input logic         shape_wide,
    input logic         zero_ext,
    input logic [1:0]   lane_sz,
    input logic [127:0] opa_wide,
    input logic [63:0]  opa_narrow,
    input logic [63:0]  opb,
    input logic [127:0] sum_out,
    input logic         bad_op
);
    if (REG_OUT) begin : g_chk
        // R5: the flag and a zero result appear together
        assert_bad_zero_R5: assert property (@(posedge clk) disable iff (rst)
            bad_op |-> (sum_out == 128'd0));

        // R5, R7: the flag follows the size code one cycle later
        assert_bad_flag_R5: assert property (@(posedge clk) disable iff (rst)
            !$past(rst) |-> (bad_op == ($past(lane_sz) == 2'b11)));

        // R1, R3: an unsigned byte sum in long shape fits in 9 bits of lane 0
        assert_ubyte_fit_R3: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(shape_wide) && $past(zero_ext) && $past(lane_sz) == 2'b00)
            |-> (sum_out[15:9] == 7'd0));

        // R2, R4: upper word lane in wide shape, unsigned, wraps on its own
        assert_wide_word_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(shape_wide) && $past(zero_ext) && $past(lane_sz) == 2'b10)
            |-> (sum_out[127:64] == ($past(opa_wide[127:64]) + {32'd0, $past(opb[63:32])})));

        // R1: lane 0 of a signed halfword long-shape add
        assert_long_half_R1: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(shape_wide) && !$past(zero_ext) && $past(lane_sz) == 2'b01)
            |-> (sum_out[31:0] == ({{16{$past(opa_narrow[15])}}, $past(opa_narrow[15:0])}
                                 + {{16{$past(opb[15])}}, $past(opb[15:0])})));
    end
endmodule

bind simd_widen_add swa_checker #(.REG_OUT(REG_OUT)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .shape_wide (shape_wide),
    .zero_ext   (zero_ext),
    .lane_sz    (lane_sz),
    .opa_wide   (opa_wide),
    .opa_narrow (opa_narrow),
    .opb        (opb),
    .sum_out    (sum_out),
    .bad_op     (bad_op)
);

// File: tb/simd_widen_add_tb_top.sv
module simd_widen_add_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         shape_wide = 1'b0;
    logic         zero_ext = 1'b0;
    logic [1:0]   lane_sz = 2'b00;
    logic [127:0] opa_wide = '0;
    logic [63:0]  opa_narrow = '0;
    logic [63:0]  opb = '0;
    logic [127:0] sum_out;
    logic         bad_op;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    simd_widen_add dut_i (
        .clk        (clk),
        .rst        (rst),
        .shape_wide (shape_wide),
        .zero_ext   (zero_ext),
        .lane_sz    (lane_sz),
        .opa_wide   (opa_wide),
        .opa_narrow (opa_narrow),
        .opb        (opb),
        .sum_out    (sum_out),
        .bad_op     (bad_op)
    );

    // Behavioural reference: loop over lanes with shifts and masks
    function automatic logic [127:0] model(input logic m, input logic u, input logic [1:0] sz,
                                           input logic [127:0] aw, input logic [63:0] an,
                                           input logic [63:0] b);
        logic [127:0] r = '0;
        if (sz == 2'b11) return '0;
        begin
            int es = 8 << sz;
            int n = 64 / es;
            logic [127:0] m1 = (128'd1 << es) - 128'd1;
            logic [127:0] m2 = (128'd1 << (2*es)) - 128'd1;
            for (int e = 0; e < n; e++) begin
                logic [127:0] av, bv, nv;
                nv = ({64'd0, an} >> (e*es)) & m1;
                if (!u && nv[es-1]) nv = nv | (m2 & ~m1);
                bv = ({64'd0, b} >> (e*es)) & m1;
                if (!u && bv[es-1]) bv = bv | (m2 & ~m1);
                av = m ? ((aw >> (e*2*es)) & m2) : nv;
                r = r | (((av + bv) & m2) << (e*2*es));
            end
        end
        return r;
    endfunction

    task automatic check(input string tag, input logic [127:0] exp_sum, input logic exp_bad);
        checks++;
        if (sum_out !== exp_sum || bad_op !== exp_bad) begin
            failures++;
            $display("FAIL %s: sum=%h bad=%b expected sum=%h bad=%b",
                     tag, sum_out, bad_op, exp_sum, exp_bad);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, check at the next falling edge
    task automatic run_vec(input string tag, input logic m, input logic u, input logic [1:0] sz,
                           input logic [127:0] aw, input logic [63:0] an, input logic [63:0] b);
        @(negedge clk);
        shape_wide = m; zero_ext = u; lane_sz = sz;
        opa_wide = aw; opa_narrow = an; opb = b;
        @(negedge clk);
        check(tag, model(m, u, sz, aw, an, b), sz == 2'b11);
    endtask

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [127:0] rw;
        repeat (3) @(negedge clk);
        check("R8 reset state", '0, 1'b0);
        rst = 1'b0;

        // R1 long shape, signed, each size
        run_vec("R1 long byte signed", 1'b0, 1'b0, 2'b00, '0,
                64'h7f80_01ff_1234_8001, 64'h0180_ff01_5678_7fff);
        run_vec("R1 long half signed", 1'b0, 1'b0, 2'b01, '0,
                64'h8000_7fff_1234_ffff, 64'h8000_0001_edcb_0001);
        run_vec("R1 long word signed", 1'b0, 1'b0, 2'b10, '0,
                64'h8000_0000_7fff_ffff, 64'hffff_ffff_0000_0001);
        // R3 extension fill
        run_vec("R3 signed ff bytes", 1'b0, 1'b0, 2'b00, '0, {8{8'hff}}, {8{8'h01}});
        check("R3 signed ff bytes value", '0, 1'b0);
        run_vec("R3 unsigned ff bytes", 1'b0, 1'b1, 2'b00, '0, {8{8'hff}}, {8{8'h01}});
        check("R3 unsigned ff bytes value", {8{16'h0100}}, 1'b0);
        // R2 wide shape
        run_vec("R2 wide half signed", 1'b1, 1'b0, 2'b01,
                128'h0001_0000_7fff_ffff_8000_0000_1234_5678, 64'hdead_beef_dead_beef,
                64'h8000_ffff_0001_7fff);
        run_vec("R2 wide word unsigned", 1'b1, 1'b1, 2'b10,
                128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, '0, 64'hffff_ffff_8000_0000);
        // R4 wrap without inter-lane carry
        run_vec("R4 wide byte wrap", 1'b1, 1'b1, 2'b00, {8{16'hffff}}, '0, {8{8'h01}});
        check("R4 wide byte wrap value", '0, 1'b0);
        run_vec("R4 wide word wrap", 1'b1, 1'b0, 2'b10, {2{64'hffff_ffff_ffff_ffff}}, '0,
                {2{32'h0000_0001}});
        check("R4 wide word wrap value", '0, 1'b0);
        // R5 invalid size
        run_vec("R5 bad size long", 1'b0, 1'b0, 2'b11, {4{32'hffff_ffff}}, {2{32'h1234_5678}},
                {2{32'h9abc_def0}});
        run_vec("R5 bad size wide", 1'b1, 1'b1, 2'b11, {4{32'ha5a5_a5a5}}, '1, '1);
        // R6 unused input ignored
        run_vec("R6 long ignores wide A", 1'b0, 1'b0, 2'b01, '1, 64'h1111_2222_3333_4444,
                64'h0f0f_f0f0_8888_7777);
        run_vec("R6 long ignores wide A alt", 1'b0, 1'b0, 2'b01, 128'h5a5a, 64'h1111_2222_3333_4444,
                64'h0f0f_f0f0_8888_7777);
        run_vec("R6 wide ignores narrow A", 1'b1, 1'b0, 2'b00, {8{16'h1234}}, '1, {8{8'h80}});
        run_vec("R6 wide ignores narrow A alt", 1'b1, 1'b0, 2'b00, {8{16'h1234}}, '0, {8{8'h80}});

        // R7 latency: result holds the previous edge's operation until the next edge
        @(negedge clk);
        shape_wide = 1'b0; zero_ext = 1'b1; lane_sz = 2'b00;
        opa_narrow = {8{8'h10}}; opb = {8{8'h01}};
        check("R7 output before capture", model(1'b1, 1'b0, 2'b00, {8{16'h1234}}, '0, {8{8'h80}}), 1'b0);
        @(negedge clk);
        check("R7 output after capture", {8{16'h0011}}, 1'b0);

        // R8 mid-run reset with live operands
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 reset mid-run", '0, 1'b0);
        rst = 1'b0;

        // Mixed random operations, R1 R2 R3 R4 R5 R7
        for (int i = 0; i < 400; i++) begin
            logic m = 1'($urandom);
            logic u = 1'($urandom);
            logic [1:0] sz = 2'($urandom);
            rw = {$urandom, $urandom, $urandom, $urandom};
            run_vec(m ? "R2 R4 random wide" : "R1 R3 random long", m, u, sz, rw,
                    {$urandom, $urandom}, {$urandom, $urandom});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule